// File: doc/BRIEF.md
# Vector Configuration Legality Checker

This block judges whether a requested vector configuration can be honoured. A request carries a configuration word and an application vector length (AVL). The word holds an element-width code and a register-grouping code (LMUL), and every bit above those two fields is reserved. Two parameters fix the machine: the widest supported element (ELEN) and the width of one vector register (VLEN).

A legal request is echoed back as the accepted configuration word. The response also carries the maximum element count for that configuration (VLMAX = VLEN·LMUL/SEW) and the granted length, which is the smaller of AVL and VLMAX. An illegal request returns a word in which only the top (illegal) bit is set, with both lengths zero.

Fractional grouping has two separate tests. The first compares the fraction against ELEN using the narrowest element width (8 bits), so the active element width plays no part in it. The second is a storage test that the active element must fit in VLEN·LMUL bits. The decision is made in the cycle the request arrives, and the result is registered one cycle later together with a done pulse.

Top module: `vcfg_validator`

## Requirements
- R1: In reset, rsp_done, rsp_vtype, rsp_vlmax, rsp_vl and rsp_ill are all zero.
- R2: Every cycle with req_valid high produces rsp_done high exactly one cycle later. A cycle without req_valid produces no rsp_done, and back-to-back requests give back-to-back responses.
- R3: The grouping code sits in bits [2:0]. Codes 0, 1, 2 and 3 mean LMUL 1, 2, 4 and 8. Codes 7, 6 and 5 mean 1/2, 1/4 and 1/8. Code 4 is reserved and always makes the request illegal.
- R4: A fractional code is legal only if ELEN shifted right by (8 − code) is at least 8, whatever the element width. With ELEN=64 codes 5, 6 and 7 pass this test. With ELEN=32 code 5 fails it and codes 6 and 7 pass. ELEN=64, SEW=16, LMUL=1/8 is not rejected by this test.
- R5: The element-width code sits in bits [5:3], and SEW = 8 << code for codes 0–3. Codes 4–7 are illegal, and so is any SEW greater than ELEN.
- R6: A request with SEW > VLEN·LMUL is illegal. For example, SEW=16 with LMUL=1/8 is illegal at VLEN=64 and legal at VLEN=128.
- R7: Any nonzero bit in req_vtype[XLEN-1:6] makes the request illegal.
- R8: For a legal request, rsp_vtype equals req_vtype, rsp_ill is 0 and rsp_vlmax equals VLEN·LMUL/SEW.
- R9: For a legal request, rsp_vl = min(req_avl, VLMAX). This holds for AVL zero, for AVL equal to VLMAX and for AVL far above VLMAX.
- R10: For an illegal request, rsp_ill is 1, rsp_vtype has only bit XLEN-1 set, and rsp_vlmax and rsp_vl are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vtype | input | XLEN | Requested configuration word |
| req_avl | input | XLEN | Application vector length |
| rsp_done | output | 1 | Response registered this cycle |
| rsp_vtype | output | XLEN | Accepted word, or only the illegal bit |
| rsp_vlmax | output | clog2(VLEN)+1 | Maximum element count, zero when illegal |
| rsp_vl | output | clog2(VLEN)+1 | Granted vector length, zero when illegal |
| rsp_ill | output | 1 | Request judged illegal |

## Verification
The bench builds three copies side by side: ELEN=64/VLEN=128, ELEN=64/VLEN=64 and ELEN=32/VLEN=64, and sends each request to all three at once. The first copy accepts SEW=16 with LMUL=1/8. The second rejects that same request through the storage test alone, and the third rejects it through the ELEN fraction test. Comparing the three copies therefore separates the two fractional tests, and the narrow-ELEN copy also exercises SEW=64 exceeding ELEN. Sweeps over every grouping and width code, AVL values around VLMAX, reserved-bit patterns and a random stream are compared against an arithmetic model kept in the bench.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
    // field placement inside the configuration word
    localparam int LMUL_LSB    = 0;
    localparam int LMUL_W      = 3;
    localparam int SEW_LSB     = 3;
    localparam int SEW_W       = 3;
    localparam int FIELD_TOP   = SEW_LSB + SEW_W;   // first reserved bit
    localparam int SEW_MIN_LOG = 3;                 // narrowest element: 8 bits

    typedef enum logic [LMUL_W-1:0] {
        LM_ONE     = 3'd0,
        LM_TWO     = 3'd1,
        LM_FOUR    = 3'd2,
        LM_EIGHT   = 3'd3,
        LM_RSVD    = 3'd4,
        LM_EIGHTH  = 3'd5,
        LM_QUARTER = 3'd6,
        LM_HALF    = 3'd7
    } lmul_code_e;

    typedef struct packed {
        lmul_code_e       lmul;
        logic [SEW_W-1:0] sew_code;
        logic             rsvd_set;
    } fields_t;

    typedef struct packed {
        logic lmul_rsvd;
        logic sew_rsvd;
        logic sew_too_wide;
        logic frac_unsupported;
        logic no_storage;
        logic rsvd_bits;
    } fault_t;

    // signed log2 of the grouping factor
    function automatic int lmul_exp(lmul_code_e c);
        int v;
        v = int'(c);
        return c[2] ? v - 8 : v;
    endfunction

    // log2 of the element width in bits (valid for codes 0..3)
    function automatic int sew_exp(logic [SEW_W-1:0] s);
        return SEW_MIN_LOG + int'({1'b0, s[1:0]});
    endfunction
endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] vtype,
    output fields_t         fld
);
    always_comb begin
        fld.lmul     = lmul_code_e'(vtype[LMUL_LSB +: LMUL_W]);
        fld.sew_code = vtype[SEW_LSB +: SEW_W];
        fld.rsvd_set = |vtype[XLEN-1:FIELD_TOP];
    end
endmodule

// File: rtl/vcfg_legal.sv
module vcfg_legal
    import vcfg_pkg::*;
#(
    parameter int ELEN = 64,
    parameter int VLEN = 128
) (
    input  fields_t fld,
    output fault_t  fault,
    output logic    illegal
);
    localparam int ELEN_LOG = $clog2(ELEN);
    localparam int VLEN_LOG = $clog2(VLEN);

    int le;
    int se;

    always_comb begin
        le = lmul_exp(fld.lmul);
        se = sew_exp(fld.sew_code);
        fault.lmul_rsvd        = (fld.lmul == LM_RSVD);
        fault.sew_rsvd         = fld.sew_code[SEW_W-1];
        fault.sew_too_wide     = !fld.sew_code[SEW_W-1] && (se > ELEN_LOG);
        // fraction judged against the narrowest element, never the active one
        fault.frac_unsupported = fld.lmul[2] && (fld.lmul != LM_RSVD)
                                 && (ELEN_LOG + le < SEW_MIN_LOG);
        // active element must fit in the grouped register bits
        fault.no_storage       = (VLEN_LOG + le < se);
        fault.rsvd_bits        = fld.rsvd_set;
        illegal                = |fault;
    end
endmodule

// File: rtl/vcfg_len.sv
module vcfg_len
    import vcfg_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int VLEN = 128
) (
    input  fields_t                  fld,
    input  logic                     legal,
    input  logic [XLEN-1:0]          avl,
    output logic [$clog2(VLEN):0]    vlmax,
    output logic [$clog2(VLEN):0]    vl
);
    localparam int VLEN_LOG = $clog2(VLEN);
    localparam int VL_W     = VLEN_LOG + 1;

    int              grant_exp;
    logic [VL_W-1:0] hit;

    always_comb grant_exp = VLEN_LOG + lmul_exp(fld.lmul) - sew_exp(fld.sew_code);

    // VLMAX is a power of two: one comparator per possible exponent
    for (genvar k = 0; k < VL_W; k++) begin : g_exp
        assign hit[k] = legal && (grant_exp == k);
    end

    assign vlmax = hit;

    always_comb begin
        if (avl < {{(XLEN-VL_W){1'b0}}, vlmax}) vl = avl[VL_W-1:0];
        else                                    vl = vlmax;
    end
endmodule

// File: rtl/vcfg_validator.sv
module vcfg_validator
    import vcfg_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ELEN = 64,
    parameter int VLEN = 128
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [XLEN-1:0]       req_vtype,
    input  logic [XLEN-1:0]       req_avl,
    output logic                  rsp_done,
    output logic [XLEN-1:0]       rsp_vtype,
    output logic [$clog2(VLEN):0] rsp_vlmax,
    output logic [$clog2(VLEN):0] rsp_vl,
    output logic                  rsp_ill
);
    localparam int              VL_W     = $clog2(VLEN) + 1;
    localparam logic [XLEN-1:0] ILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

    fields_t         fld;
    fault_t          flt;
    logic            bad;
    logic [VL_W-1:0] vlmax_c;
    logic [VL_W-1:0] vl_c;

    vcfg_decode #(.XLEN(XLEN)) u_dec (
        .vtype (req_vtype),
        .fld   (fld)
    );

    vcfg_legal #(.ELEN(ELEN), .VLEN(VLEN)) u_leg (
        .fld     (fld),
        .fault   (flt),
        .illegal (bad)
    );

    vcfg_len #(.XLEN(XLEN), .VLEN(VLEN)) u_len (
        .fld   (fld),
        .legal (!bad),
        .avl   (req_avl),
        .vlmax (vlmax_c),
        .vl    (vl_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_vtype <= '0;
            rsp_vlmax <= '0;
            rsp_vl    <= '0;
            rsp_ill   <= 1'b0;
        end else begin
            rsp_done <= req_valid;
            if (req_valid) begin
                rsp_ill   <= bad;
                rsp_vtype <= bad ? ILL_WORD : req_vtype;
                rsp_vlmax <= vlmax_c;
                rsp_vl    <= vl_c;
            end
        end
    end

    // R2
    req_to_done_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done);
    // R2
    idle_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_done);
    // R10
    ill_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_ill |-> (rsp_vtype == ILL_WORD && rsp_vlmax == '0 && rsp_vl == '0));
    // R3
    lmul_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_vtype[2:0] == 3'd4) |=> rsp_ill);
    // R4
    frac_elen_chk: assert property (@(posedge clk) disable iff (rst)
        (ELEN < 64 && req_valid && req_vtype[2:0] == 3'd5) |=> rsp_ill);
    // R5
    sew_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_vtype[5]) |=> rsp_ill);
    // R7
    rsvd_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (|req_vtype[XLEN-1:6])) |=> rsp_ill);
    // R8
    vlmax_pow2_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !rsp_ill) |-> ($countones(rsp_vlmax) == 1));
    // R9
    vl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_vl <= rsp_vlmax);
endmodule

// File: tb/sim_vcfg_validator.sv
`timescale 1ns/1ps
module sim_vcfg_validator;
    typedef struct {
        logic [31:0] vtype;
        longint      vlmax;
        longint      vl;
        logic        ill;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vtype = '0;
    logic [31:0] req_avl = '0;

    logic        done0, done1, done2, ill0, ill1, ill2;
    logic [31:0] vt0, vt1, vt2;
    logic [7:0]  vlmax0, vl0;
    logic [6:0]  vlmax1, vl1, vlmax2, vl2;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    exp_t q0[$];
    exp_t q1[$];
    exp_t q2[$];

    always #2.5 clk = ~clk;

    vcfg_validator #(.XLEN(32), .ELEN(64), .VLEN(128)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vtype(req_vtype), .req_avl(req_avl),
        .rsp_done(done0), .rsp_vtype(vt0), .rsp_vlmax(vlmax0), .rsp_vl(vl0), .rsp_ill(ill0));
    vcfg_validator #(.XLEN(32), .ELEN(64), .VLEN(64)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vtype(req_vtype), .req_avl(req_avl),
        .rsp_done(done1), .rsp_vtype(vt1), .rsp_vlmax(vlmax1), .rsp_vl(vl1), .rsp_ill(ill1));
    vcfg_validator #(.XLEN(32), .ELEN(32), .VLEN(64)) u2 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vtype(req_vtype), .req_avl(req_avl),
        .rsp_done(done2), .rsp_vtype(vt2), .rsp_vlmax(vlmax2), .rsp_vl(vl2), .rsp_ill(ill2));

    // arithmetic model written from the requirements
    function automatic exp_t model(int elen, int vlen, logic [31:0] vt, logic [31:0] avl, string tag);
        exp_t e;
        int lm, sv, sew, num, den;
        bit bad;
        lm = int'(vt[2:0]);
        sv = int'(vt[5:3]);
        bad = (vt[31:6] != 0) || (sv > 3) || (lm == 4);
        sew = 8 << (sv % 4);
        if (lm < 4) begin num = 1 << lm; den = 1; end
        else begin num = 1; den = 1 << (8 - lm); end
        if (sew > elen) bad = 1;
        if (lm > 4 && (elen / den) < 8) bad = 1;
        if (sew * den > vlen * num) bad = 1;
        e.tag = tag;
        if (bad) begin
            e.vtype = 32'h8000_0000; e.vlmax = 0; e.vl = 0; e.ill = 1'b1;
        end else begin
            e.vtype = vt; e.ill = 1'b0;
            e.vlmax = longint'(vlen * num / (sew * den));
            e.vl = (longint'(avl) < e.vlmax) ? longint'(avl) : e.vlmax;
        end
        return e;
    endfunction

    task automatic send(input logic [31:0] vt, input logic [31:0] avl, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_vtype = vt;
        req_avl   = avl;
        q0.push_back(model(64, 128, vt, avl, tag));
        q1.push_back(model(64, 64, vt, avl, tag));
        q2.push_back(model(32, 64, vt, avl, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_vtype = $urandom;
            req_avl   = $urandom;
        end
    endtask

    function automatic logic [31:0] word(input int sv, input int lm);
        return 32'((sv << 3) | lm);
    endfunction

    task automatic compare(input int idx, input logic done, input logic [31:0] vt,
                           input longint vlmax, input longint vl, input logic ill);
        exp_t e;
        int n;
        case (idx)
            0: n = q0.size();
            1: n = q1.size();
            default: n = q2.size();
        endcase
        if (done) begin
            checks++;
            if (n == 0) begin
                errors++;
                $display("FAIL R2 inst%0d: done act 1 exp 0", idx);
            end else begin
                case (idx)
                    0: e = q0.pop_front();
                    1: e = q1.pop_front();
                    default: e = q2.pop_front();
                endcase
                if (vt !== e.vtype || vlmax != e.vlmax || vl != e.vl || ill !== e.ill) begin
                    errors++;
                    $display("FAIL %s inst%0d: act vtype=%h vlmax=%0d vl=%0d ill=%b exp vtype=%h vlmax=%0d vl=%0d ill=%b",
                             e.tag, idx, vt, vlmax, vl, ill, e.vtype, e.vlmax, e.vl, e.ill);
                end
            end
        end else if (n != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 inst%0d: done act 0 exp 1", idx);
            case (idx)
                0: void'(q0.pop_front());
                1: void'(q1.pop_front());
                default: void'(q2.pop_front());
            endcase
        end
    endtask

    // monitor: outputs settle after the edge, sample 1 ns later
    always begin
        @(posedge clk);
        #1;
        if (!rst) begin
            compare(0, done0, vt0, longint'(vlmax0), longint'(vl0), ill0);
            compare(1, done1, vt1, longint'(vlmax1), longint'(vl1), ill1);
            compare(2, done2, vt2, longint'(vlmax2), longint'(vl2), ill2);
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: act running exp finished");
        finish_run();
    end

    initial begin
        req_valid = 1'b1;          // R1: a request during reset must not leak out
        req_vtype = 32'h0000_0008;
        repeat (3) @(negedge clk);
        checks++;
        if (done0 || vt0 != 0 || vlmax0 != 0 || vl0 != 0 || ill0) begin
            errors++;
            $display("FAIL R1: act done=%b vtype=%h vlmax=%0d vl=%0d ill=%b exp all zero",
                     done0, vt0, vlmax0, vl0, ill0);
        end
        req_valid = 1'b0;
        rst = 1'b0;
        idle(2);

        // R8: plain LMUL 1 / SEW 8, then SEW 64 (R5: too wide for ELEN 32)
        send(word(0, 0), 32'd1000, "R8");
        send(word(3, 0), 32'd1000, "R5");
        idle(1);
        // R3: every grouping code with SEW 8
        for (int lm = 0; lm < 8; lm++) send(word(0, lm), 32'hFFFF_FFFF, "R3");
        idle(2);
        // R4 / R6: SEW 16 with LMUL 1/8 splits the three copies
        send(word(1, 5), 32'd50, "R4");
        send(word(0, 5), 32'd50, "R4");
        send(word(0, 6), 32'd50, "R4");
        send(word(2, 7), 32'd50, "R6");
        send(word(3, 7), 32'd50, "R6");
        idle(1);
        // R5: every width code with LMUL 1
        for (int sv = 0; sv < 8; sv++) send(word(sv, 0), 32'd7, "R5");
        idle(1);
        // R7: reserved bits
        send(32'h0000_0040, 32'd4, "R7");
        send(32'h8000_0000, 32'd4, "R7");
        send(32'h0010_0009, 32'd4, "R7");
        idle(1);
        // R9: AVL around VLMAX (u0 LMUL 2 SEW 16 gives 16)
        send(word(1, 1), 32'd0, "R9");
        send(word(1, 1), 32'd15, "R9");
        send(word(1, 1), 32'd16, "R9");
        send(word(1, 1), 32'd17, "R9");
        send(word(1, 1), 32'hFFFF_FFFF, "R9");
        idle(3);
        // R10: illegal right after legal, outputs must clear
        send(word(0, 3), 32'd200, "R8");
        send(word(0, 4), 32'd200, "R10");
        send(word(0, 3), 32'd200, "R8");
        idle(2);
        // R2 plus general mix: random stream with idle gaps
        for (int i = 0; i < 400; i++) begin
            logic [31:0] v;
            v = {26'd0, 6'($urandom)};
            if (($urandom % 10) == 0) v[6 + ($urandom % 26)] = 1'b1;
            send(v, $urandom % 300, "R2");
            if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
        end
        idle(4);
        finish_run();
    end
endmodule